// File: doc/BRIEF.md
# I2C Transmit Byte Queue with Acknowledge-Failure Halt

This block is a byte queue that sits between software register writes and the byte engine of an I2C controller. While the queue is switched on, every write to the data port stores one byte. A drain unit hands the stored bytes to the byte engine in order, one at a time. It waits for the engine to report the acknowledge result of each byte before it offers the next one. START and STOP conditions are generated elsewhere, by the command sequencer.

When the addressed device refuses a byte (NAK), draining stops at once. A sticky no-acknowledge flag is raised and a bus-level NAK indication comes up. The bytes that have not been sent stay in the queue. They are not transmitted until software flushes the queue and loads new data. A single control register holds the flush bit and the enable bit. The flush bit reads back as set for exactly one cycle and then clears itself. A status register reports whether the queue is empty. Three interrupt flags record a completed drain, a refused byte and a write to a full queue. Software clears each flag by writing a one to it.

Top module: `i2c_txq`

## Requirements
- R1: After reset the interrupt flags read 0, the status register reads 0x10 (queue empty), the control register reads 0, `bus_nak` is 0 and no byte is offered to the engine.
- R2: With the enable bit (control bit 6) set, each `data_wr` stores one byte, and the bytes reach `eng_byte` in the order they were written.
- R3: With the enable bit clear, `data_wr` stores nothing and no byte is offered to the engine, even if bytes are already queued.
- R4: The queue holds 64 bytes. A write while it is full is dropped and sets interrupt flag bit 2 (overflow). The occupancy never exceeds 64.
- R5: A byte is handed over in the cycle where `eng_valid` and `eng_ready` are both high. After that, `eng_valid` stays low until the engine reports `eng_done`, so only one byte is outstanding at a time.
- R6: An `eng_done` with `eng_nak` high sets interrupt flag bit 0 and raises `bus_nak`. From then on no byte is offered, even when new data is written, until a flush.
- R7: An `eng_done` with `eng_nak` low that leaves the queue empty sets interrupt flag bit 1 (drained).
- R8: Writing control bit 7 empties the queue and clears `bus_nak`. A data write in the same cycle is dropped. Bit 7 reads back as 1 in the following cycle only.
- R9: Status register bit 4 reads 1 exactly when the queue is empty. All other status bits read 0.
- R10: Writing 1 to an interrupt flag bit through `isr_wr` clears that bit and leaves the other bits unchanged. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 8 | Byte to store |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value: bit 7 flush, bit 6 enable |
| isr_wr | input | 1 | Interrupt flag clear strobe |
| isr_wdata | input | 8 | Write-one-to-clear mask for flag bits 2..0 |
| ctl_rdata | output | 8 | Control readback: bit 7 flush pulse, bit 6 enable |
| fifo_status | output | 8 | Bit 4 is queue empty |
| irq_status | output | 8 | Bit 0 no-ack, bit 1 drained, bit 2 overflow |
| bus_nak | output | 1 | High while draining is halted by a refused byte |
| eng_valid | output | 1 | A byte is offered to the engine |
| eng_byte | output | 8 | Offered byte |
| eng_ready | input | 1 | Engine accepts the offered byte |
| eng_done | input | 1 | Engine finished the outstanding byte |
| eng_nak | input | 1 | With eng_done: the byte was refused |

## Verification
The checker watches several properties on every cycle. No byte is offered while the drain is halted or while the queue is switched off. An accepted byte is followed by a low `eng_valid`. The occupancy stays within 64. A flush leaves the queue empty and reads back for one cycle only. A refused byte always raises the no-ack flag and `bus_nak`. Other behaviour can only be shown by the bench scenarios, because it depends on data values across a whole transfer. That includes the byte order seen by the engine and exactly which byte was dropped on overflow. It also includes how many bytes go out before a NAK at a given position, whether the drained flag appears only after an acknowledged final byte, and the recovery sequence of flush followed by fresh data.

// File: rtl/i2c_txq_pkg.sv
package i2c_txq_pkg;
  localparam int CTL_FLUSH_BIT   = 7;
  localparam int CTL_EN_BIT      = 6;
  localparam int FST_EMPTY_BIT   = 4;
  localparam int IRQ_NOACK_BIT   = 0;
  localparam int IRQ_DRAINED_BIT = 1;
  localparam int IRQ_OVF_BIT     = 2;
  localparam int IRQ_W           = 3;

  typedef enum logic [1:0] {
    DR_IDLE = 2'd0,
    DR_BUSY = 2'd1,
    DR_HALT = 2'd2
  } drain_state_e;
endpackage

// File: rtl/i2c_txq_store.sv
module i2c_txq_store #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          clear,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full && !clear;
  assign pop_ok  = pop && !empty && !clear;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clear) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/i2c_txq_drain.sv
module i2c_txq_drain
  import i2c_txq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          q_empty,
  input  logic [DW-1:0] q_head,
  input  logic          flush,
  input  logic          eng_ready,
  input  logic          eng_done,
  input  logic          eng_nak,
  output logic          eng_valid,
  output logic [DW-1:0] eng_byte,
  output logic          pop,
  output logic          busy,
  output logic          halted,
  output logic          byte_acked,
  output logic          byte_refused
);
  drain_state_e st_q, st_d;

  assign eng_valid    = (st_q == DR_IDLE) && enable && !q_empty;
  assign eng_byte     = q_head;
  assign pop          = eng_valid && eng_ready;
  assign busy         = (st_q == DR_BUSY);
  assign halted       = (st_q == DR_HALT);
  assign byte_acked   = busy && eng_done && !eng_nak;
  assign byte_refused = busy && eng_done && eng_nak;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      DR_IDLE: if (pop) st_d = DR_BUSY;
      DR_BUSY: begin
        if (eng_done) st_d = (eng_nak && !flush) ? DR_HALT : DR_IDLE;
      end
      DR_HALT: if (flush) st_d = DR_IDLE;
      default: st_d = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DR_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/i2c_txq_flags.sv
module i2c_txq_flags
  import i2c_txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_noack,
  input  logic              set_drained,
  input  logic              set_ovf,
  input  logic              clr_wr,
  input  logic [IRQ_W-1:0]  clr_mask,
  output logic [IRQ_W-1:0]  flags
);
  logic [IRQ_W-1:0] flg_q, flg_d, set_vec;

  always_comb begin
    set_vec                  = '0;
    set_vec[IRQ_NOACK_BIT]   = set_noack;
    set_vec[IRQ_DRAINED_BIT] = set_drained;
    set_vec[IRQ_OVF_BIT]     = set_ovf;
    flg_d = flg_q;
    if (clr_wr) flg_d = flg_d & ~clr_mask;
    flg_d = flg_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/i2c_txq.sv
module i2c_txq
  import i2c_txq_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] data_in,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          isr_wr,
  input  logic [7:0]    isr_wdata,
  output logic [7:0]    ctl_rdata,
  output logic [7:0]    fifo_status,
  output logic [7:0]    irq_status,
  output logic          bus_nak,
  output logic          eng_valid,
  output logic [DW-1:0] eng_byte,
  input  logic          eng_ready,
  input  logic          eng_done,
  input  logic          eng_nak
);
  logic          en_q, en_d;
  logic          flush_q, flush_d;
  logic          flush_now;
  logic          q_push, q_pop, q_empty, q_full;
  logic [DW-1:0] q_head;
  logic [CW-1:0] fifo_cnt;
  logic          drn_busy, drn_halted, drn_acked, drn_refused;
  logic [IRQ_W-1:0] irq_flags;
  logic          unused_wbits;

  assign unused_wbits = ^{ctl_wdata[5:0], isr_wdata[7:3]};

  assign flush_now = ctl_wr && ctl_wdata[CTL_FLUSH_BIT];

  always_comb begin
    en_d    = en_q;
    flush_d = 1'b0;
    if (ctl_wr) begin
      en_d    = ctl_wdata[CTL_EN_BIT];
      flush_d = ctl_wdata[CTL_FLUSH_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      flush_q <= flush_d;
    end
  end

  assign q_push = data_wr && en_q;

  i2c_txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (data_in),
    .pop       (q_pop),
    .clear     (flush_now),
    .head      (q_head),
    .count     (fifo_cnt),
    .empty     (q_empty),
    .full      (q_full)
  );

  i2c_txq_drain #(.DW(DW)) u_drain (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (en_q),
    .q_empty      (q_empty),
    .q_head       (q_head),
    .flush        (flush_now),
    .eng_ready    (eng_ready),
    .eng_done     (eng_done),
    .eng_nak      (eng_nak),
    .eng_valid    (eng_valid),
    .eng_byte     (eng_byte),
    .pop          (q_pop),
    .busy         (drn_busy),
    .halted       (drn_halted),
    .byte_acked   (drn_acked),
    .byte_refused (drn_refused)
  );

  i2c_txq_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_noack   (drn_refused),
    .set_drained (drn_acked && q_empty),
    .set_ovf     (q_push && q_full && !flush_now),
    .clr_wr      (isr_wr),
    .clr_mask    (isr_wdata[IRQ_W-1:0]),
    .flags       (irq_flags)
  );

  always_comb begin
    ctl_rdata                = '0;
    ctl_rdata[CTL_FLUSH_BIT] = flush_q;
    ctl_rdata[CTL_EN_BIT]    = en_q;
    fifo_status                = '0;
    fifo_status[FST_EMPTY_BIT] = q_empty;
    irq_status            = '0;
    irq_status[IRQ_W-1:0] = irq_flags;
  end

  assign bus_nak = drn_halted;
endmodule

// File: rtl/i2c_txq_chk.sv
module i2c_txq_chk #(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_wr,
  input logic          ctl_wr,
  input logic [7:0]    ctl_wdata,
  input logic [7:0]    ctl_rdata,
  input logic [7:0]    fifo_status,
  input logic [7:0]    irq_status,
  input logic          bus_nak,
  input logic          eng_valid,
  input logic          eng_ready,
  input logic          eng_done,
  input logic          eng_nak,
  input logic [CW-1:0] cnt,
  input logic          busy
);
  // R6: halted drain offers nothing
  a_r6_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    bus_nak |-> !eng_valid);

  // R6: a refused byte raises both indications
  a_r6_noack_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && eng_nak && !(ctl_wr && ctl_wdata[7])) |=> (bus_nak && irq_status[0]));

  // R3: switched-off queue offers nothing
  a_r3_off_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[6] |-> !eng_valid);

  // R3: switched-off queue does not grow
  a_r3_off_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ctl_rdata[6] && !ctl_wr) |=> (cnt <= $past(cnt)));

  // R4: occupancy bound
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R4: write to full queue flags overflow
  a_r4_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ctl_rdata[6] && cnt == CW'(DEPTH) && !(ctl_wr && ctl_wdata[7])) |=> irq_status[2]);

  // R5: one byte outstanding
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && eng_ready) |=> !eng_valid);

  // R8: flush empties and releases the halt
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[7]) |=> (fifo_status[4] && !bus_nak && ctl_rdata[7]));

  // R8: flush bit lasts one cycle
  a_r8_flush_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] && !ctl_wr) |=> !ctl_rdata[7]);

  // R9: empty status tracks occupancy
  a_r9_empty_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_status[4] == (cnt == '0));
endmodule

bind i2c_txq i2c_txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .data_wr     (data_wr),
  .ctl_wr      (ctl_wr),
  .ctl_wdata   (ctl_wdata),
  .ctl_rdata   (ctl_rdata),
  .fifo_status (fifo_status),
  .irq_status  (irq_status),
  .bus_nak     (bus_nak),
  .eng_valid   (eng_valid),
  .eng_ready   (eng_ready),
  .eng_done    (eng_done),
  .eng_nak     (eng_nak),
  .cnt         (fifo_cnt),
  .busy        (drn_busy)
);

// File: tb/test_i2c_txq.sv
module test_i2c_txq;
  logic       clk;
  logic       rst_n;
  logic       data_wr;
  logic [7:0] data_in;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic       isr_wr;
  logic [7:0] isr_wdata;
  logic [7:0] ctl_rdata, fifo_status, irq_status;
  logic       bus_nak, eng_valid;
  logic [7:0] eng_byte;
  logic       eng_ready, eng_done, eng_nak;

  int n_chk = 0;
  int n_bad = 0;

  i2c_txq i_i2c_txq (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .isr_wr(isr_wr), .isr_wdata(isr_wdata),
    .ctl_rdata(ctl_rdata), .fifo_status(fifo_status), .irq_status(irq_status),
    .bus_nak(bus_nak), .eng_valid(eng_valid), .eng_byte(eng_byte),
    .eng_ready(eng_ready), .eng_done(eng_done), .eng_nak(eng_nak)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {count, refused index (FF = none), first byte}
  localparam logic [23:0] VEC [6] = '{
    {8'd1,  8'hFF, 8'hA0},
    {8'd5,  8'hFF, 8'h10},
    {8'd5,  8'd2,  8'h30},
    {8'd4,  8'd0,  8'h50},
    {8'd6,  8'd5,  8'h70},
    {8'd64, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic clr_irq(input logic [7:0] m);
    @(negedge clk); isr_wr = 1'b1; isr_wdata = m;
    @(negedge clk); isr_wr = 1'b0; isr_wdata = '0;
  endtask

  task automatic push(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_wr = 1'b1; data_in = base + 8'(i);
    end
    @(negedge clk); data_wr = 1'b0;
  endtask

  // engine model: accept offered bytes, refuse the one at index nak_at
  task automatic run_engine(input int nak_at, input logic [7:0] base, output int sent);
    int idle = 0;
    sent = 0;
    while (idle < 6) begin
      @(negedge clk);
      if (eng_valid) begin
        chk("R2 byte order", int'(eng_byte), int'(base + 8'(sent)));
        eng_ready = 1'b1;
        @(negedge clk); eng_ready = 1'b0;
        chk("R5 no offer while outstanding", int'(eng_valid), 0);
        eng_done = 1'b1; eng_nak = (sent == nak_at);
        @(negedge clk); eng_done = 1'b0; eng_nak = 1'b0;
        sent++;
        idle = 0;
      end else begin
        idle++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sent;
    rst_n = 1'b0; data_wr = 0; data_in = 0; ctl_wr = 0; ctl_wdata = 0;
    isr_wr = 0; isr_wdata = 0; eng_ready = 0; eng_done = 0; eng_nak = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq_status), 0);
    chk("R1 status", int'(fifo_status), 'h10);
    chk("R1 ctl", int'(ctl_rdata), 0);
    chk("R1 nak", int'(bus_nak), 0);
    chk("R1 valid", int'(eng_valid), 0);

    // vector table
    foreach (VEC[k]) begin
      int n, nk;
      logic [7:0] b;
      logic refused;
      n = int'(VEC[k][23:16]); nk = int'(VEC[k][15:8]); b = VEC[k][7:0];
      refused = (nk < n);
      ctl(8'hC0);
      clr_irq(8'h07);
      push(n, b);
      chk("R9 not empty after push", int'(fifo_status), 0);
      run_engine(nk, b, sent);
      chk("R6 bytes sent", sent, refused ? nk + 1 : n);
      chk("R6 noack flag", int'(irq_status[0]), int'(refused));
      chk("R7 drained flag", int'(irq_status[1]), int'(!refused));
      chk("R6 bus_nak", int'(bus_nak), int'(refused));
      chk("R9 empty status", int'(fifo_status), (!refused || nk == n - 1) ? 'h10 : 0);
    end

    // R8 flush readback for exactly one cycle
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'hC0;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 8'h00;
    chk("R8 flush reads 1", int'(ctl_rdata), 'hC0);
    @(negedge clk);
    chk("R8 flush self-clears", int'(ctl_rdata), 'h40);

    // R10 write-one-to-clear, only selected bits
    clr_irq(8'h07);
    push(1, 8'h22);
    run_engine(99, 8'h22, sent);
    push(1, 8'h23);
    run_engine(0, 8'h23, sent);
    chk("R10 both set", int'(irq_status), 'h03);
    clr_irq(8'h01);
    chk("R10 clear bit0 only", int'(irq_status), 'h02);
    clr_irq(8'h02);
    chk("R10 clear bit1", int'(irq_status), 0);

    // R6 no resume without flush, then resume after flush + new data
    push(2, 8'h60);
    run_engine(99, 8'h60, sent);
    chk("R6 halted ignores new data", sent, 0);
    ctl(8'hC0);
    chk("R8 flush clears bus_nak", int'(bus_nak), 0);
    chk("R8 flush empties", int'(fifo_status), 'h10);
    push(2, 8'h90);
    run_engine(99, 8'h90, sent);
    chk("R6 resume after flush", sent, 2);

    // R3 disabled: no store, no offer of queued bytes
    ctl(8'h80);
    push(3, 8'h11);
    chk("R3 disabled write ignored", int'(fifo_status), 'h10);
    ctl(8'h40);
    push(2, 8'h44);
    ctl(8'h00);
    run_engine(99, 8'h44, sent);
    chk("R3 disabled no drain", sent, 0);
    ctl(8'h40);
    run_engine(99, 8'h44, sent);
    chk("R3 drains once enabled", sent, 2);

    // R4 overflow: 65 writes, last dropped
    ctl(8'hC0);
    clr_irq(8'h07);
    push(65, 8'h00);
    chk("R4 overflow flag", int'(irq_status[2]), 1);
    run_engine(999, 8'h00, sent);
    chk("R4 only 64 kept", sent, 64);
    chk("R7 drained after full", int'(irq_status[1]), 1);

    // R8 data write in flush cycle dropped
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'hC0; data_wr = 1'b1; data_in = 8'h5A;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 8'h00; data_wr = 1'b0;
    chk("R8 write in flush cycle dropped", int'(fifo_status), 'h10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule